// File: doc/BRIEF.md
# Bit-Serial Shift Integer ALU

This block produces the integer result of a 32-bit RISC-V style core for both register-register and register-immediate arithmetic and logic operations. The operation is selected by the 3-bit function code. A separate flag tells the block whether the instruction has the register-register form. A second flag, the instruction's alternate bit (bit 30), picks subtract over add and arithmetic over logical right shift. Add, subtract, both less-than comparisons and the three bitwise operations are combinational, so the result is valid in the same cycle as the operands.

Shifts are iterative and cost little area. On the cycle the core pulses the trigger with a shift function code, a small state machine loads the first operand into a shift register and loads the shift amount from the low five bits of the second operand. The value then moves one bit position per clock while a down-counter runs to zero. The core polls `busy` and reads `result` once it has fallen. The machine has two states. `SH_IDLE` waits for a trigger. It takes the transition *start* to `SH_RUN` when the amount is nonzero; a zero amount leaves it in `SH_IDLE`. `SH_RUN` steps the value and takes the transition *done* back to `SH_IDLE` on the cycle the count reaches zero. Synchronous reset takes the transition *clear* to `SH_IDLE` from either state.

Top module: `serial_shift_alu`

## Requirements
- R1: Function code 000 gives `opa - opb` when `reg_form` is 1 and `alt_bit` is 1. In all other cases it gives `opa + opb`, so the immediate form always adds. The result wraps modulo 2^32.
- R2: Function code 010 gives 1 when `opa` is less than `opb` as signed two's complement numbers, else 0. Function code 011 makes the same comparison unsigned. Bits 31..1 of the result are zero for both codes.
- R3: Function code 100 gives bitwise XOR, 110 gives bitwise OR and 111 gives bitwise AND of the two operands.
- R4: For every non-shift function code the result follows the inputs in the same cycle with no clock edge, and `busy` stays low.
- R5: A shift (function code 001 or 101) starts only on a rising clock edge where `trig` is 1 while `busy` is 0. The shift amount is `opb[4:0]`; bits 31..5 of `opb` have no effect.
- R6: After a start with amount n, `busy` is 1 for exactly n clock cycles following the start edge. With n = 0, `busy` never rises and the result is valid right after the start edge.
- R7: Function code 001 shifts left with zero fill. When `busy` falls the result equals `opa << n` of the operand captured at the start.
- R8: Function code 101 shifts right. When `alt_bit` is 0 the fill is zero; when it is 1 the fill copies bit 31. The fill choice is captured at the start.
- R9: While idle with a shift function code applied, the result holds the last shift outcome. Changes to `opa` or `opb`, and a trigger with a non-shift function code, leave it unchanged.
- R10: A trigger while `busy` is 1 is ignored: neither the remaining cycle count nor the final result changes.
- R11: Synchronous reset makes `busy` 0 and clears the shift register, so a shift function code reads 0 after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| trig | input | 1 | One-cycle pulse that starts a shift |
| funct3 | input | 3 | Operation select |
| reg_form | input | 1 | 1 for register-register form, 0 for immediate form |
| alt_bit | input | 1 | Instruction bit 30: subtract / arithmetic right shift |
| opa | input | 32 | First operand |
| opb | input | 32 | Second operand (register or immediate) |
| result | output | 32 | Operation result |
| busy | output | 1 | High while a shift is in progress |

## Verification
A wrong shift count shows up at the ports as a `busy` pulse that is too long or too short. The error is visible on the edge where `busy` should fall, at most 31 cycles after the start. A wrong direction or fill latch shows up as a wrong result word on the first idle cycle after the shift. A shift register that loads when it should not shows up as a change in the held result on the very next edge. The bench runs every shift amount for each of the three shift kinds and measures the `busy` length in cycles. It also sweeps the combinational operations over corner and pseudo-random operands, with every combination of form and alternate bit.

// File: rtl/ssalu_pkg.sv
package ssalu_pkg;

    typedef enum logic [2:0] {
        F3_ADD  = 3'b000,
        F3_SLL  = 3'b001,
        F3_SLT  = 3'b010,
        F3_SLTU = 3'b011,
        F3_XOR  = 3'b100,
        F3_SRX  = 3'b101,
        F3_OR   = 3'b110,
        F3_AND  = 3'b111
    } op_sel_e;

    typedef enum logic {
        SH_IDLE = 1'b0,
        SH_RUN  = 1'b1
    } sh_state_e;

    typedef enum logic [1:0] {
        MV_LEFT  = 2'd0,
        MV_RZERO = 2'd1,
        MV_RSIGN = 2'd2
    } sh_mode_e;

endpackage

// File: rtl/ssalu_addsub.sv
module ssalu_addsub #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    input  logic            sub_en,
    output logic [XLEN-1:0] sum,
    output logic            lt_s,
    output logic            lt_u
);
    localparam int MSB = XLEN - 1;

    logic [XLEN:0]   diff_w;
    logic [XLEN-1:0] plus_w;

    // one widened adder: a + ~b + 1; top bit set means a < b unsigned
    always_comb begin
        diff_w = {1'b1, ~b} + {1'b0, a} + {{XLEN{1'b0}}, 1'b1};
        plus_w = a + b;
        lt_u   = diff_w[XLEN];
        lt_s   = (a[MSB] ^ b[MSB]) ? a[MSB] : diff_w[XLEN];
        sum    = sub_en ? diff_w[XLEN-1:0] : plus_w;
    end
endmodule

// File: rtl/ssalu_logic.sv
module ssalu_logic #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    input  logic [1:0]      sel,
    output logic [XLEN-1:0] y
);
    always_comb begin
        case (sel)
            2'b00:   y = a ^ b;
            2'b10:   y = a | b;
            2'b11:   y = a & b;
            default: y = '0;
        endcase
    end
endmodule

// File: rtl/ssalu_shifter.sv
module ssalu_shifter
    import ssalu_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int SHW  = $clog2(XLEN)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  sh_mode_e        mode_in,
    input  logic [SHW-1:0]  amt,
    input  logic [XLEN-1:0] din,
    output logic [XLEN-1:0] dout,
    output logic            busy
);
    localparam logic [SHW-1:0] CNT_ONE = SHW'(1);

    sh_state_e       state_q, state_d;
    logic [SHW-1:0]  cnt_q;
    logic [XLEN-1:0] sreg_q;
    sh_mode_e        mode_q;

    function automatic logic [XLEN-1:0] step1(input logic [XLEN-1:0] v, input sh_mode_e m);
        case (m)
            MV_LEFT:  step1 = {v[XLEN-2:0], 1'b0};
            MV_RZERO: step1 = {1'b0, v[XLEN-1:1]};
            MV_RSIGN: step1 = {v[XLEN-1], v[XLEN-1:1]};
            default:  step1 = v;
        endcase
    endfunction

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SH_IDLE: if (start && amt != '0)   state_d = SH_RUN;   // start
            SH_RUN:  if (cnt_q == CNT_ONE)     state_d = SH_IDLE;  // done
        endcase
    end

    // state register and datapath registers
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SH_IDLE;                                    // clear
            cnt_q   <= '0;
            sreg_q  <= '0;
            mode_q  <= MV_LEFT;
        end else begin
            state_q <= state_d;
            unique case (state_q)
                SH_IDLE: begin
                    if (start) begin
                        cnt_q  <= amt;
                        sreg_q <= din;
                        mode_q <= mode_in;
                    end
                end
                SH_RUN: begin
                    cnt_q  <= cnt_q - CNT_ONE;
                    sreg_q <= step1(sreg_q, mode_q);
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        busy = (state_q == SH_RUN);
        dout = sreg_q;
    end
endmodule

// File: rtl/serial_shift_alu.sv
module serial_shift_alu
    import ssalu_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            trig,
    input  logic [2:0]      funct3,
    input  logic            reg_form,
    input  logic            alt_bit,
    input  logic [XLEN-1:0] opa,
    input  logic [XLEN-1:0] opb,
    output logic [XLEN-1:0] result,
    output logic            busy
);
    localparam int SHW = $clog2(XLEN);

    op_sel_e         op;
    logic            is_shift;
    sh_mode_e        mode_sel;
    logic [XLEN-1:0] arith_y, logic_y, shift_y;
    logic            lt_s, lt_u;

    always_comb begin
        op       = op_sel_e'(funct3);
        is_shift = (op == F3_SLL) || (op == F3_SRX);
        if (op == F3_SLL)  mode_sel = MV_LEFT;
        else if (alt_bit)  mode_sel = MV_RSIGN;
        else               mode_sel = MV_RZERO;
    end

    ssalu_addsub #(.XLEN(XLEN)) addsub_i (
        .a      (opa),
        .b      (opb),
        .sub_en (reg_form & alt_bit),
        .sum    (arith_y),
        .lt_s   (lt_s),
        .lt_u   (lt_u)
    );

    ssalu_logic #(.XLEN(XLEN)) logic_i (
        .a   (opa),
        .b   (opb),
        .sel (funct3[1:0]),
        .y   (logic_y)
    );

    ssalu_shifter #(.XLEN(XLEN), .SHW(SHW)) shifter_i (
        .clk     (clk),
        .rst     (rst),
        .start   (trig & is_shift),
        .mode_in (mode_sel),
        .amt     (opb[SHW-1:0]),
        .din     (opa),
        .dout    (shift_y),
        .busy    (busy)
    );

    always_comb begin
        unique case (op)
            F3_ADD:          result = arith_y;
            F3_SLT:          result = {{(XLEN-1){1'b0}}, lt_s};
            F3_SLTU:         result = {{(XLEN-1){1'b0}}, lt_u};
            F3_XOR, F3_OR,
            F3_AND:          result = logic_y;
            F3_SLL, F3_SRX:  result = shift_y;
        endcase
    end
endmodule

// File: rtl/serial_shift_alu_chk.sv
module serial_shift_alu_chk #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst,
    input logic            trig,
    input logic [2:0]      funct3,
    input logic            reg_form,
    input logic [XLEN-1:0] opa,
    input logic [XLEN-1:0] opb,
    input logic [XLEN-1:0] result,
    input logic            busy
);
    localparam int SHW = $clog2(XLEN);

    logic sh_code;
    assign sh_code = (funct3 == 3'b001) || (funct3 == 3'b101);

    AST_IMM_ADDS: assert property (@(posedge clk) disable iff (rst)
        (funct3 == 3'b000 && !reg_form) |-> (result == opa + opb));          // R1

    AST_CMP_ONE_BIT: assert property (@(posedge clk) disable iff (rst)
        (funct3 == 3'b010 || funct3 == 3'b011) |-> (result[XLEN-1:1] == '0)); // R2

    AST_START_BUSY: assert property (@(posedge clk) disable iff (rst)
        (trig && sh_code && !busy && opb[SHW-1:0] != '0) |=> busy);          // R6

    AST_ZERO_AMT_IDLE: assert property (@(posedge clk) disable iff (rst)
        (trig && sh_code && !busy && opb[SHW-1:0] == '0) |=> !busy);         // R6

    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (rst)
        (!busy && !$past(busy) && !$past(trig) && sh_code && $past(sh_code))
            |-> $stable(result));                                            // R9

    AST_RESET_IDLE: assert property (@(posedge clk)
        $past(rst) |-> !busy);                                               // R11
endmodule

bind serial_shift_alu serial_shift_alu_chk #(.XLEN(XLEN)) chk_i (.*);

// File: tb/serial_shift_alu_tb.sv
module serial_shift_alu_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        trig = 1'b0;
    logic [2:0]  funct3 = 3'b000;
    logic        reg_form = 1'b0;
    logic        alt_bit = 1'b0;
    logic [31:0] opa = '0;
    logic [31:0] opb = '0;
    logic [31:0] result;
    logic        busy;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    serial_shift_alu #(.XLEN(32)) dut_i (
        .clk(clk), .rst(rst), .trig(trig), .funct3(funct3),
        .reg_form(reg_form), .alt_bit(alt_bit), .opa(opa), .opb(opb),
        .result(result), .busy(busy)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] model_comb(input logic [2:0] f, input bit rf, input bit alt,
                                               input logic [31:0] a, input logic [31:0] b);
        case (f)
            3'b000:  model_comb = (rf && alt) ? a - b : a + b;
            3'b010:  model_comb = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
            3'b011:  model_comb = (a < b) ? 32'd1 : 32'd0;
            3'b100:  model_comb = a ^ b;
            3'b110:  model_comb = a | b;
            default: model_comb = a & b;
        endcase
    endfunction

    task automatic comb_case(input logic [31:0] a, input logic [31:0] b);
        logic [2:0] codes [6] = '{3'b000, 3'b010, 3'b011, 3'b100, 3'b110, 3'b111};
        for (int k = 0; k < 6; k++) begin
            for (int m = 0; m < 4; m++) begin
                logic [31:0] e;
                funct3 = codes[k]; reg_form = m[0]; alt_bit = m[1]; opa = a; opb = b;
                #1;
                e = model_comb(codes[k], m[0], m[1], a, b);
                case (codes[k])
                    3'b000:         chk(result == e, "R1", result, e);
                    3'b010, 3'b011: chk(result == e, "R2", result, e);
                    default:        chk(result == e, "R3", result, e);
                endcase
                chk(busy == 1'b0, "R4", {31'd0, busy}, 32'd0);
            end
        end
    endtask

    // starts a shift at the next edge and measures busy length and final value
    task automatic run_shift(input logic [2:0] f, input bit alt, input logic [31:0] a,
                             input logic [31:0] b, input bit inject);
        int n, cnt;
        logic [31:0] e;
        string rq;
        n = int'(b[4:0]);
        if (f == 3'b001)  e = a << n;
        else if (alt)     e = $unsigned($signed(a) >>> n);
        else              e = a >> n;
        rq = (f == 3'b001) ? "R7" : "R8";
        @(negedge clk);
        funct3 = f; alt_bit = alt; reg_form = 1'b0; opa = a; opb = b; trig = 1'b1;
        @(posedge clk); #1;
        trig = 1'b0;
        chk(busy == (n != 0), "R6", {31'd0, busy}, {31'd0, n != 0});
        cnt = 0;
        while (busy && cnt < 40) begin
            if (inject && cnt == 1) begin
                trig = 1'b1; opa = ~a; opb = 32'd2; alt_bit = ~alt;
            end
            @(posedge clk); #1;
            trig = 1'b0; opa = a; opb = b; alt_bit = alt;
            cnt++;
        end
        chk(cnt == n, inject ? "R10" : "R6", cnt, n);
        chk(result == e, inject ? "R10" : rq, result, e);
        // hold while idle: operand changes
        opa = ~a; opb = a ^ 32'h1357_9bdf; #1;
        chk(result == e, "R9", result, e);
        // trigger with a non-shift code, then return to the shift code
        @(negedge clk);
        funct3 = 3'b110; trig = 1'b1;
        @(posedge clk); #1;
        trig = 1'b0; funct3 = f;
        @(posedge clk); #1;
        chk(result == e && !busy, "R9", result, e);
    endtask

    initial begin
        logic [31:0] lf;
        logic [31:0] sh_ops [3] = '{32'h8000_0001, 32'hF0F0_1234, 32'h7FFF_FFFE};
        // reset state
        funct3 = 3'b001;
        repeat (3) @(posedge clk);
        #1;
        chk(busy == 1'b0, "R11", {31'd0, busy}, 32'd0);
        chk(result == 32'd0, "R11", result, 32'd0);
        @(negedge clk);
        rst = 1'b0;

        // combinational sweep: corners then pseudo-random
        comb_case(32'h0000_0000, 32'h0000_0000);
        comb_case(32'h7FFF_FFFF, 32'h8000_0000);
        comb_case(32'h8000_0000, 32'h7FFF_FFFF);
        comb_case(32'hFFFF_FFFF, 32'h0000_0001);
        comb_case(32'h0000_0001, 32'hFFFF_FFFF);
        comb_case(32'h1234_5678, 32'h1234_5678);
        lf = 32'hACE1_2468;
        for (int i = 0; i < 40; i++) begin
            logic [31:0] p;
            p = lf;
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            comb_case(p, lf ^ 32'h9E37_79B9);
        end

        // every shift amount for every shift kind; upper opb bits set (R5)
        for (int o = 0; o < 3; o++) begin
            for (int s = 0; s < 32; s++) begin
                logic [31:0] b;
                b = {27'h5A5_A5A5, 5'(s)};
                run_shift(3'b001, 1'b0, sh_ops[o], b, 1'b0);   // R5 R7
                run_shift(3'b101, 1'b0, sh_ops[o], b, 1'b0);   // R5 R8
                run_shift(3'b101, 1'b1, sh_ops[o], b, 1'b0);   // R5 R8
            end
        end

        // trigger during busy ignored
        run_shift(3'b101, 1'b1, 32'h8421_0F0F, 32'd5, 1'b1);  // R10
        run_shift(3'b001, 1'b0, 32'h0000_00FF, 32'd31, 1'b1); // R10

        // reset in the middle of a shift
        @(negedge clk);
        funct3 = 3'b001; opa = 32'hFFFF_FFFF; opb = 32'd20; trig = 1'b1;
        @(posedge clk); #1;
        trig = 1'b0;
        repeat (3) @(posedge clk);
        #1; rst = 1'b1;
        @(posedge clk); #1;
        rst = 1'b0;
        chk(busy == 1'b0, "R11", {31'd0, busy}, 32'd0);
        chk(result == 32'd0, "R11", result, 32'd0);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule